// File: doc/BRIEF.md
# Bit-Masked General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port behind a small word-addressed register interface. Each pin has a direction bit and a stored data bit. A pin set as an output drives its stored data bit and asserts its output enable. A pin set as an input is sampled through a two-stage synchronizer, and reads of that pin return the sampled level.

The data register is mapped many times over. It is visible at 256 consecutive word addresses, and the byte-address bits [9:2] of each location act as a per-pin mask. A write at a given location changes only the pins whose mask bit is set. A read returns data only in the masked positions. Firmware can therefore set, clear or load any group of pins with one store and no read-modify-write, and it can poll a single pin by reading the location whose mask holds only that pin. The direction register sits just above the data window. All other addresses are inert.

Top module: `gpio_mask_port`

## Requirements
- R1: Direction bit i set to 1 makes pin i an output and sets `pin_oe[i]`. Set to 0, it makes the pin an input and clears `pin_oe[i]`. `pin_oe` follows a direction write from the clock edge that accepts the write.
- R2: `pin_out[i]` always equals the stored data bit i, whatever the direction, and changes at the edge that accepts a data write.
- R3: A byte address whose bits [11:10] and [1:0] are all zero selects the data register, and bits [9:2] of that address form the mask. Mask bit k (address bit k+2) governs pin k.
- R4: A data write loads `bus_wdata[k]` into stored bit k where mask bit k is 1. Every stored bit whose mask bit is 0 keeps its value.
- R5: A data read returns 0 in every bit position whose mask bit is 0.
- R6: For an input pin, a masked read returns the synchronized pin level. A level sampled on `pin_in` at clock edge n is returned on `bus_rdata` after edge n+2 (two synchronizer stages, then the read register).
- R7: For an output pin, a masked read returns the stored data bit.
- R8: A data write to a pin that is currently an input still updates its stored bit. That value appears on `pin_oe`/`pin_out` drive when the pin is later switched to output.
- R9: The direction register is at byte address 0x400. It can be read and written as a full byte and resets to 0x00, so all pins start as inputs.
- R10: Reads are registered. `bus_rdata` reflects the address presented before a clock edge, from that edge on. A read and a write to the same location in one cycle return the contents from before the write.
- R11: Every other address (0x404 to 0xFFC, and any address with bits [1:0] non-zero) reads as 0. Writes there change neither the stored data nor the direction.
- R12: `rst_n` low clears direction, data and `bus_rdata` at once, without waiting for a clock. Its release is synchronized to `clk` internally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Value driven toward the pads |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
Two functions can act in the same cycle: a read and a write to the same masked location, and a direction change or a pin-level change while a read of that pin is in flight. The bench sets up both cases. It issues a write and holds the same address in the next cycle. It also flips a pin's direction while toggling `pin_in` under a continuous masked read. A behavioural model compares `bus_rdata`, `pin_out` and `pin_oe` on every clock. That model keeps a queue of past pin levels, a stored byte and a direction byte, and it computes read data from the values held before each edge. A correct design therefore shows old data on a same-cycle read and write, and shows the pin level from two edges back on an input pin.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Region picked out by one bus address.
  typedef enum logic [1:0] {
    REGION_NONE = 2'd0,
    REGION_DATA = 2'd1,
    REGION_DIR  = 2'd2
  } region_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;

  // Counts edges since reset so the latency check never looks before reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_out == $past(async_in, 2))); // R6

endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [PIN_W-1:0]  mask
);

  localparam int WORD_W   = ADDR_W - 2;
  localparam int HIGH_W   = WORD_W - PIN_W;
  localparam int DIR_WORD = 1 << PIN_W;

  logic [WORD_W-1:0] word_addr;
  logic [HIGH_W-1:0] high_bits;
  logic              aligned;

  always_comb begin
    word_addr = addr[ADDR_W-1:2];
    high_bits = word_addr[WORD_W-1:PIN_W];
    aligned   = (addr[1:0] == 2'b00);
    mask      = word_addr[PIN_W-1:0];
    if (!aligned) begin
      region = REGION_NONE;
    end else if (high_bits == '0) begin
      region = REGION_DATA;
    end else if (word_addr == WORD_W'(DIR_WORD)) begin
      region = REGION_DIR;
    end else begin
      region = REGION_NONE;
    end
  end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic             dir_we,
  input  logic [PIN_W-1:0] mask,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] pin_sync,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] out_q,
  output logic [PIN_W-1:0] level
);

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    logic dir_d;
    logic out_en;
    logic out_d;

    // Next-state logic for one pin.
    always_comb begin
      dir_d  = wdata[i];
      out_en = data_we & mask[i];
      out_d  = wdata[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[i] <= 1'b0;
      end else if (dir_we) begin
        dir_q[i] <= dir_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[i] <= 1'b0;
      end else if (out_en) begin
        out_q[i] <= out_d;
      end
    end

    // Readable level: driven value for outputs, sampled pad for inputs.
    always_comb begin
      level[i] = dir_q[i] ? out_q[i] : pin_sync[i];
    end
  end

  AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> ((out_q & $past(mask)) == ($past(wdata) & $past(mask)))); // R4
  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0)); // R4
  AST_DATA_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(out_q)); // R11
  AST_DIR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q)); // R11

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);

  logic             rst_sync_n;
  region_e          region;
  logic [PIN_W-1:0] mask;
  logic [PIN_W-1:0] pin_sync;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] out_q;
  logic [PIN_W-1:0] level;
  logic             data_we;
  logic             dir_we;
  logic [PIN_W-1:0] rdata_d;
  logic [PIN_W-1:0] rdata_q;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(PIN_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_bus_decode #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .region (region),
    .mask   (mask)
  );

  always_comb begin
    data_we = bus_we && (region == REGION_DATA);
    dir_we  = bus_we && (region == REGION_DIR);
  end

  gpio_pin_bank #(.PIN_W(PIN_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .data_we  (data_we),
    .dir_we   (dir_we),
    .mask     (mask),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .level    (level)
  );

  // Read path: next value, then register.
  always_comb begin
    unique case (region)
      REGION_DATA: rdata_d = level & mask;
      REGION_DIR:  rdata_d = dir_q;
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;

  AST_RDATA_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (region == REGION_DATA) |=> ((bus_rdata & ~$past(mask)) == '0)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (region == REGION_NONE) |=> (bus_rdata == '0)); // R11
  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (region == REGION_DIR) |=> (bus_rdata == $past(pin_oe))); // R9
  AST_OUTPUT_READBACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (region == REGION_DATA) |=> ((bus_rdata & $past(mask) & $past(pin_oe)) ==
                                  ($past(pin_out) & $past(mask) & $past(pin_oe)))); // R7

endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;

  localparam int PIN_W  = 8;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [PIN_W-1:0]  bus_wdata;
  logic [PIN_W-1:0]  bus_rdata;
  logic [PIN_W-1:0]  pin_in;
  logic [PIN_W-1:0]  pin_out;
  logic [PIN_W-1:0]  pin_oe;

  always #5 clk = ~clk;

  gpio_mask_port #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R12";
  bit    done     = 1'b0;

  // Behavioural reference model.
  logic [7:0] m_dir;
  logic [7:0] m_out;
  logic [7:0] m_rdata;
  logic [7:0] pin_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir    = 8'h00;
      m_out    = 8'h00;
      m_rdata  = 8'h00;
      pin_hist = {8'h00, 8'h00};
    end else begin
      logic [7:0] old_pin;
      logic [7:0] msk;
      logic [7:0] view;
      int         word;
      old_pin = pin_hist[pin_hist.size()-2];
      word    = int'(bus_addr) / 4;
      msk     = 8'(word % 256);
      if (bus_addr[1:0] != 2'b00) begin
        m_rdata = 8'h00;
      end else if (word < 256) begin
        view    = (m_dir & m_out) | (~m_dir & old_pin);
        m_rdata = view & msk;
        if (bus_we) m_out = (m_out & ~msk) | (bus_wdata & msk);
      end else if (word == 256) begin
        m_rdata = m_dir;
        if (bus_we) m_dir = bus_wdata;
      end else begin
        m_rdata = 8'h00;
      end
      pin_hist.push_back(pin_in);
      if (pin_hist.size() > 3) void'(pin_hist.pop_front());
    end
  end

  task automatic check8(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // Compare at the falling edge, then drive the next inputs.
  task automatic step(input logic [11:0] a, input logic we, input logic [7:0] wd,
                      input logic [7:0] pins);
    @(negedge clk);
    check8("bus_rdata", bus_rdata, m_rdata);
    check8("pin_out", pin_out, m_out);
    check8("pin_oe", pin_oe, m_dir);
    bus_addr  = a;
    bus_we    = we;
    bus_wdata = wd;
    pin_in    = pins;
  endtask

  function automatic logic [11:0] data_at(input logic [7:0] msk);
    return {2'b00, msk, 2'b00};
  endfunction

  localparam logic [11:0] DIR_ADDR = 12'h400;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pins;
    logic [15:0] lfsr;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    tag = "R12";
    check8("reset rdata", bus_rdata, 8'h00);
    check8("reset pin_oe R9", pin_oe, 8'h00);
    check8("reset pin_out", pin_out, 8'h00);
    rst_n = 1'b1;
    repeat (4) step(12'h000, 1'b0, 8'h00, 8'h00);

    tag = "R9/R1";
    step(DIR_ADDR, 1'b1, 8'h0F, 8'h00);
    step(DIR_ADDR, 1'b0, 8'h00, 8'h00);
    step(12'h000, 1'b0, 8'h00, 8'h00);

    tag = "R3/R2";
    step(data_at(8'hFF), 1'b1, 8'hA5, 8'h00);
    step(data_at(8'h00), 1'b0, 8'h00, 8'h00);

    tag = "R4";
    step(data_at(8'h03), 1'b1, 8'hFF, 8'h00);
    step(data_at(8'h05), 1'b1, 8'h00, 8'h00);
    step(data_at(8'h80), 1'b1, 8'h00, 8'h00);
    step(data_at(8'hFF), 1'b0, 8'h00, 8'h00);

    tag = "R5/R7";
    step(data_at(8'h0C), 1'b0, 8'h00, 8'hF0);
    step(data_at(8'h01), 1'b0, 8'h00, 8'hF0);
    step(data_at(8'hF0), 1'b0, 8'h00, 8'hF0);

    tag = "R6";
    for (int k = 0; k < 12; k++) begin
      pins = 8'((k * 37) ^ (k << 4));
      step(data_at(8'hF0), 1'b0, 8'h00, pins);
    end

    tag = "R10";
    step(data_at(8'h0F), 1'b1, 8'h3C, 8'h00);
    step(data_at(8'h0F), 1'b1, 8'hC3, 8'h00);
    step(data_at(8'h0F), 1'b0, 8'h00, 8'h00);
    step(12'h000, 1'b0, 8'h00, 8'h00);

    tag = "R8";
    step(data_at(8'hF0), 1'b1, 8'h90, 8'hFF);
    step(data_at(8'hF0), 1'b0, 8'h00, 8'h00);
    step(DIR_ADDR, 1'b1, 8'hFF, 8'h55);
    step(data_at(8'hFF), 1'b0, 8'h00, 8'h55);
    step(DIR_ADDR, 1'b1, 8'h00, 8'hAA);
    step(data_at(8'hFF), 1'b0, 8'h00, 8'hAA);
    step(data_at(8'hFF), 1'b0, 8'h00, 8'hAA);

    tag = "R11";
    step(12'h800, 1'b1, 8'hFF, 8'h11);
    step(12'h404, 1'b1, 8'hFF, 8'h11);
    step(12'h401, 1'b1, 8'hFF, 8'h11);
    step(12'h3FD, 1'b1, 8'h00, 8'h11);
    step(12'hFFC, 1'b0, 8'h00, 8'h11);
    step(DIR_ADDR, 1'b0, 8'h00, 8'h11);
    step(data_at(8'hFF), 1'b0, 8'h00, 8'h11);

    tag = "R1/R6";
    for (int k = 0; k < 16; k++) begin
      pins = 8'(k * 29 + 3);
      if (k % 4 == 0) step(DIR_ADDR, 1'b1, 8'(k * 17), pins);
      else            step(data_at(8'hFF), 1'b0, 8'h00, pins);
    end

    tag = "R4/R10";
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [11:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: a = DIR_ADDR;
        2'd1: a = {lfsr[15:14], lfsr[9:2], 2'b00};
        default: a = data_at(lfsr[11:4]);
      endcase
      step(a, lfsr[12], lfsr[15:8] ^ lfsr[7:0], lfsr[13:6]);
    end
    step(12'h000, 1'b0, 8'h00, 8'h00);
    step(12'h000, 1'b0, 8'h00, 8'h00);

    tag = "R12";
    step(DIR_ADDR, 1'b1, 8'hFF, 8'h00);
    step(data_at(8'hFF), 1'b1, 8'h77, 8'h00);
    step(DIR_ADDR, 1'b0, 8'h00, 8'h00);
    @(negedge clk);
    bus_addr = 12'h000; bus_we = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check8("async pin_oe", pin_oe, 8'h00);
    check8("async pin_out", pin_out, 8'h00);
    check8("async rdata", bus_rdata, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(12'h000, 1'b0, 8'h00, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule